// File: doc/BRIEF.md
# Dual-Slope Soft Mute Controller

This block fades a stereo sample stream down to near silence when a mute is requested, and brings it back up when the request goes away. The level is a 16-bit unsigned gain that moves in a straight line, one step per sample strobe. Because the gain never jumps, neither engaging nor releasing the mute makes an audible click. If the request is dropped partway through a fade-out, the fade turns round at the current gain and climbs back from there.

A mute can be requested in two ways: by a control-register bit, or by an active-low external pin. Either one alone is enough. The pin passes through a synchronizer that resets to the inactive level, so a pin left undriven at its pulled-up level does not mute. A second control bit picks a fast or a slow slope. The step sizes come from the sample rate and two target times, each measured to the -20 dB point, so the defaults meet the targets at 48 kHz. A status output tells software whether the mute is engaged.

Top module: `soft_mute_ramp`

## Requirements
- R1: The mute request is high when `mute_bit` is 1 or when `mute_pin_n` is 0, with either one enough on its own. The pin goes through a two-flop synchronizer that resets to 1 (not muting), so a pin change reaches the request two clocks later.
- R2: The fade step is a fixed amount per strobe. With `slow_sel` = 0 the step is 1228, which takes the gain from 0xFFFF to a tenth of full scale (-20 dB) in 1 ms at 48 kHz. With `slow_sel` = 1 the step is 35, for 35 ms.
- R3: On each strobe while the request is high, the gain falls by one step. It clamps at a floor of 16, about -72 dB.
- R4: On each strobe while the request is low, the gain rises by one step and clamps at 0xFFFF. A release in mid-fade reverses from the current gain, with no jump.
- R5: The gain changes only on clocks where `smp_stb` is high.
- R6: On a strobe, each output register loads the signed input times the gain in force before that strobe's update. The product is arithmetically shifted right by 16 and saturated to 16 bits. Between strobes the outputs hold their value.
- R7: `sm_flag` is high on the clock after any clock where the request is high or the gain is below 0xFFFF. It is low on the clock after a clock where the request is low and the gain is 0xFFFF.
- R8: Synchronous active-high reset sets the gain to 0xFFFF, both outputs to 0 and `sm_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-clock strobe marking a new sample pair |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| mute_bit | input | 1 | Control-register mute request, high active |
| slow_sel | input | 1 | Slope select: 0 fast, 1 slow |
| mute_pin_n | input | 1 | External mute request, low active, asynchronous |
| out_l | output | 16 | Left scaled sample, signed |
| out_r | output | 16 | Right scaled sample, signed |
| sm_flag | output | 1 | Soft mute engaged status |

## Verification
The assertions check the following on every cycle:
- the gain stays within its floor and ceiling;
- the gain and the outputs stay still between strobes;
- the gain moves in the direction the request calls for, by exactly the slow step where the slow slope is selected;
- the status flag follows the request and the gain;
- the reset values.

Only the bench scenarios can show the following:
- the actual sample values after scaling, including negative full scale;
- the synchronizer delay on the pin;
- a full fade to the floor and back on each slope;
- a fade that reverses in mid-ramp.

// File: rtl/smr_pkg.sv
package smr_pkg;
   typedef enum logic {SLOPE_FAST = 1'b0, SLOPE_SLOW = 1'b1} slope_e;

   function automatic int calc_step(input int gain_w, input int rate_hz, input int time_us);
      int full;
      int drop;
      int samples;
      full    = (1 << gain_w) - 1;
      drop    = (full / 10) * 9;
      samples = (rate_hz / 1000) * time_us / 1000;
      if (samples < 1) samples = 1;
      return drop / samples;
   endfunction
endpackage

// File: rtl/smr_sync.sv
module smr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/smr_ramp.sv
module smr_ramp #(
   parameter int GAIN_W    = 16,
   parameter int FLOOR     = 16,
   parameter int FAST_STEP = 1228,
   parameter int SLOW_STEP = 35
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stb,
   input  logic              req,
   input  smr_pkg::slope_e   slope,
   output logic [GAIN_W-1:0] gain
);
   localparam logic [GAIN_W:0] TOP_G = {1'b0, {GAIN_W{1'b1}}};
   localparam logic [GAIN_W:0] FLR_G = (GAIN_W+1)'(FLOOR);
   localparam logic [GAIN_W:0] ST_F  = (GAIN_W+1)'(FAST_STEP);
   localparam logic [GAIN_W:0] ST_S  = (GAIN_W+1)'(SLOW_STEP);

   logic [GAIN_W:0]   ext;
   logic [GAIN_W:0]   step;
   logic [GAIN_W-1:0] gain_n;

   always_comb begin
      ext  = {1'b0, gain};
      step = (slope == smr_pkg::SLOPE_SLOW) ? ST_S : ST_F;
      if (req) begin
         if (ext > FLR_G + step) gain_n = GAIN_W'(ext - step);
         else                    gain_n = GAIN_W'(FLR_G);
      end else begin
         if (ext + step < TOP_G) gain_n = GAIN_W'(ext + step);
         else                    gain_n = GAIN_W'(TOP_G);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)      gain <= '1;
      else if (stb) gain <= gain_n;
   end
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
   parameter int SAMPLE_W = 16,
   parameter int GAIN_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       stb,
   input  logic signed [SAMPLE_W-1:0] din,
   input  logic        [GAIN_W-1:0]   gain,
   output logic signed [SAMPLE_W-1:0] dout
);
   localparam int PW = SAMPLE_W + GAIN_W + 1;
   localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (SAMPLE_W-1)) - 64'sd1);
   localparam logic signed [PW-1:0] LO = -HI - PW'(1);

   logic signed [PW-1:0]       prod;
   logic signed [PW-1:0]       shifted;
   logic signed [SAMPLE_W-1:0] res;

   assign prod    = $signed(din) * $signed({1'b0, gain});
   assign shifted = prod >>> GAIN_W;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (shifted > HI)      res = HI[SAMPLE_W-1:0];
            else if (shifted < LO) res = LO[SAMPLE_W-1:0];
            else                   res = shifted[SAMPLE_W-1:0];
         end
      end else begin : g_wrap
         assign res = shifted[SAMPLE_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      dout <= '0;
      else if (stb) dout <= res;
   end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
   parameter int SAMPLE_W    = 16,
   parameter int GAIN_W      = 16,
   parameter int GAIN_FLOOR  = 16,
   parameter int SAMPLE_RATE = 48000,
   parameter int FAST_US     = 1000,
   parameter int SLOW_US     = 35000,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       smp_stb,
   input  logic signed [SAMPLE_W-1:0] in_l,
   input  logic signed [SAMPLE_W-1:0] in_r,
   input  logic                       mute_bit,
   input  logic                       slow_sel,
   input  logic                       mute_pin_n,
   output logic signed [SAMPLE_W-1:0] out_l,
   output logic signed [SAMPLE_W-1:0] out_r,
   output logic                       sm_flag
);
   localparam int FAST_STEP = smr_pkg::calc_step(GAIN_W, SAMPLE_RATE, FAST_US);
   localparam int SLOW_STEP = smr_pkg::calc_step(GAIN_W, SAMPLE_RATE, SLOW_US);
   localparam int N_CH      = 2;

   generate
      if (GAIN_W < 4 || GAIN_W > 24 || SAMPLE_W < 2) begin : g_bad_width
         $error("soft_mute_ramp: unsupported width");
      end
      if (GAIN_FLOOR < 1 || GAIN_FLOOR >= (1 << GAIN_W) - 1) begin : g_bad_floor
         $error("soft_mute_ramp: floor out of range");
      end
      if (SLOW_STEP < 1 || FAST_STEP < SLOW_STEP) begin : g_bad_step
         $error("soft_mute_ramp: slope times give unusable steps");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("soft_mute_ramp: need at least two sync stages");
      end
   endgenerate

   logic              pin_s;
   logic              req_w;
   logic [GAIN_W-1:0] gain_w;
   smr_pkg::slope_e   slope_w;

   smr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (mute_pin_n),
      .dout(pin_s)
   );

   assign req_w   = mute_bit | ~pin_s;
   assign slope_w = slow_sel ? smr_pkg::SLOPE_SLOW : smr_pkg::SLOPE_FAST;

   smr_ramp #(
      .GAIN_W   (GAIN_W),
      .FLOOR    (GAIN_FLOOR),
      .FAST_STEP(FAST_STEP),
      .SLOW_STEP(SLOW_STEP)
   ) u_ramp (
      .clk  (clk),
      .rst  (rst),
      .stb  (smp_stb),
      .req  (req_w),
      .slope(slope_w),
      .gain (gain_w)
   );

   logic signed [SAMPLE_W-1:0] ch_in  [N_CH];
   logic signed [SAMPLE_W-1:0] ch_out [N_CH];

   assign ch_in[0] = in_l;
   assign ch_in[1] = in_r;

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         smr_scaler #(
            .SAMPLE_W(SAMPLE_W),
            .GAIN_W  (GAIN_W),
            .SATURATE(SATURATE)
         ) u_scl (
            .clk (clk),
            .rst (rst),
            .stb (smp_stb),
            .din (ch_in[c]),
            .gain(gain_w),
            .dout(ch_out[c])
         );
      end
   endgenerate

   assign out_l = ch_out[0];
   assign out_r = ch_out[1];

   always_ff @(posedge clk) begin
      if (rst) sm_flag <= 1'b0;
      else     sm_flag <= req_w | (gain_w != '1);
   end
endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
   parameter int SAMPLE_W   = 16,
   parameter int GAIN_W     = 16,
   parameter int GAIN_FLOOR = 16,
   parameter int SLOW_STEP  = 35
) (
   input logic                clk,
   input logic                rst,
   input logic                smp_stb,
   input logic                req_w,
   input logic                slow_sel,
   input logic [GAIN_W-1:0]   gain_w,
   input logic [SAMPLE_W-1:0] out_l,
   input logic [SAMPLE_W-1:0] out_r,
   input logic                sm_flag
);
   localparam logic [GAIN_W-1:0] TOP_G = '1;

   // R8: reset values
   a_r8_reset_state: assert property (@(posedge clk)
      rst |=> (gain_w == TOP_G && out_l == '0 && out_r == '0 && !sm_flag));

   // R3: floor is never crossed
   a_r3_floor: assert property (@(posedge clk) disable iff (rst)
      int'(gain_w) >= GAIN_FLOOR);

   // R5: gain frozen without strobe
   a_r5_gain_hold: assert property (@(posedge clk) disable iff (rst)
      !smp_stb |=> $stable(gain_w));

   // R6: outputs frozen without strobe
   a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
      !smp_stb |=> ($stable(out_l) && $stable(out_r)));

   // R3: fading down under a request
   a_r3_falls: assert property (@(posedge clk) disable iff (rst)
      (smp_stb && req_w && int'(gain_w) > GAIN_FLOOR) |=> gain_w < $past(gain_w));

   // R4: rising after release
   a_r4_rises: assert property (@(posedge clk) disable iff (rst)
      (smp_stb && !req_w && gain_w != TOP_G) |=> gain_w > $past(gain_w));

   // R2: slow slope moves by exactly the slow step
   a_r2_slow_step: assert property (@(posedge clk) disable iff (rst)
      (smp_stb && req_w && slow_sel && int'(gain_w) > GAIN_FLOOR + SLOW_STEP)
      |=> int'(gain_w) == int'($past(gain_w)) - SLOW_STEP);

   // R7: status tracks request and gain
   a_r7_flag_on: assert property (@(posedge clk) disable iff (rst)
      (req_w || gain_w != TOP_G) |=> sm_flag);

   a_r7_flag_off: assert property (@(posedge clk) disable iff (rst)
      (!req_w && gain_w == TOP_G) |=> !sm_flag);
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .GAIN_W    (GAIN_W),
   .GAIN_FLOOR(GAIN_FLOOR),
   .SLOW_STEP (SLOW_STEP)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .smp_stb (smp_stb),
   .req_w   (req_w),
   .slow_sel(slow_sel),
   .gain_w  (gain_w),
   .out_l   (out_l),
   .out_r   (out_r),
   .sm_flag (sm_flag)
);

// File: tb/soft_mute_ramp_bench.sv
module soft_mute_ramp_bench;
   localparam int FAST = 1228;   // R2
   localparam int SLOW = 35;     // R2
   localparam int FLR  = 16;     // R3
   localparam int TOPV = 65535;  // R4

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               smp_stb = 1'b0;
   logic signed [15:0] in_l = '0;
   logic signed [15:0] in_r = '0;
   logic               mute_bit = 1'b0;
   logic               slow_sel = 1'b0;
   logic               mute_pin_n = 1'b1;
   logic signed [15:0] out_l;
   logic signed [15:0] out_r;
   logic               sm_flag;

   int n_run  = 0;
   int n_fail = 0;
   int mg     = TOPV;
   bit m_req  = 1'b0;

   logic signed [15:0] q_l[$];
   logic signed [15:0] q_r[$];
   string              q_tag[$];

   always #2 clk = ~clk;

   soft_mute_ramp u_soft_mute_ramp (
      .clk       (clk),
      .rst       (rst),
      .smp_stb   (smp_stb),
      .in_l      (in_l),
      .in_r      (in_r),
      .mute_bit  (mute_bit),
      .slow_sel  (slow_sel),
      .mute_pin_n(mute_pin_n),
      .out_l     (out_l),
      .out_r     (out_r),
      .sm_flag   (sm_flag)
   );

   function automatic logic signed [15:0] mscale(input logic signed [15:0] x, input int g);
      longint p;
      p = longint'(x) * longint'(g);
      p = p >>> 16;
      if (p > 32767)  p = 32767;
      if (p < -32768) p = -32768;
      return 16'(p);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: one strobe, expected result pushed to scoreboard
   task automatic send(input logic signed [15:0] l, input logic signed [15:0] r, input string tag);
      int st;
      in_l    = l;
      in_r    = r;
      smp_stb = 1'b1;
      q_l.push_back(mscale(l, mg));
      q_r.push_back(mscale(r, mg));
      q_tag.push_back(tag);
      st = slow_sel ? SLOW : FAST;
      if (m_req) mg = (mg - st < FLR) ? FLR : mg - st;
      else       mg = (mg + st > TOPV) ? TOPV : mg + st;
      @(negedge clk);
      smp_stb = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         if (smp_stb) begin
            @(negedge clk);
            if (q_l.size() == 0) begin
               check(1'b0, "R6 unexpected strobe", 0, 1);
            end else begin
               logic signed [15:0] el;
               logic signed [15:0] er;
               string t;
               el = q_l.pop_front();
               er = q_r.pop_front();
               t  = q_tag.pop_front();
               check(out_l == el, {t, " left"}, out_l, el);
               check(out_r == er, {t, " right"}, out_r, er);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      settle(3);
      rst = 1'b0;
      @(negedge clk);
      // R8: reset state
      check(out_l == 0 && out_r == 0, "R8 outputs", out_l, 0);
      check(sm_flag == 1'b0, "R8 flag", sm_flag, 0);

      // R6: full-gain scaling, varied patterns
      send(16'sd1000, -16'sd1000, "R6 full gain");
      send(16'sd32767, -16'sd32768, "R6 extremes");
      send(16'sd1, -16'sd1, "R6 tiny");
      settle(3);
      // R5/R6: outputs hold between strobes
      check(out_l == mscale(16'sd1, TOPV), "R5 hold left", out_l, mscale(16'sd1, TOPV));
      check(sm_flag == 1'b0, "R7 idle flag", sm_flag, 0);

      // R1/R3 fast fade by register bit
      mute_bit = 1'b1; m_req = 1'b1;
      @(negedge clk);
      check(sm_flag == 1'b1, "R7 flag after bit", sm_flag, 1);
      for (int i = 0; i < 60; i++) send(16'sd32767, -16'sd20000, "R3 fast fade");
      send(16'sd32767, -16'sd32768, "R3 at floor");
      check(mg == FLR, "R3 model floor", mg, FLR);
      settle(2);
      check(out_l == 16'sd7, "R3 floor level", out_l, 7);

      // R4 release and reverse mid-ramp
      mute_bit = 1'b0; m_req = 1'b0;
      for (int i = 0; i < 10; i++) send(16'sd12345, 16'sd30000, "R4 rise");
      mute_bit = 1'b1; m_req = 1'b1;
      for (int i = 0; i < 4; i++) send(16'sd12345, 16'sd30000, "R4 reverse down");
      mute_bit = 1'b0; m_req = 1'b0;
      for (int i = 0; i < 60; i++) send(-16'sd30000, 16'sd9999, "R4 back to full");
      settle(2);
      check(sm_flag == 1'b0, "R7 flag after full", sm_flag, 0);

      // R1/R2 pin request with slow slope
      slow_sel = 1'b1;
      mute_pin_n = 1'b0;
      @(negedge clk);
      check(sm_flag == 1'b0, "R1 sync delay", sm_flag, 0);
      m_req = 1'b1;
      settle(3);
      check(sm_flag == 1'b1, "R1 pin flag", sm_flag, 1);
      for (int i = 0; i < 100; i++) send(16'sd32767, -16'sd32768, "R2 slow fade");
      check(mg == TOPV - 100 * SLOW, "R2 slow model", mg, TOPV - 100 * SLOW);
      mute_pin_n = 1'b1;
      settle(3);
      m_req = 1'b0;
      // R7: still engaged while gain below full
      check(sm_flag == 1'b1, "R7 flag during rise", sm_flag, 1);
      for (int i = 0; i < 101; i++) send(16'sd32767, -16'sd32768, "R4 slow rise");
      settle(2);
      check(sm_flag == 1'b0, "R7 flag released", sm_flag, 0);

      // R1: both sources together, then bit alone with fast slope
      slow_sel = 1'b0;
      mute_pin_n = 1'b0; mute_bit = 1'b1;
      settle(3);
      m_req = 1'b1;
      for (int i = 0; i < 5; i++) send(-16'sd4000, 16'sd4000, "R1 both sources");
      mute_pin_n = 1'b1;
      settle(3);
      for (int i = 0; i < 5; i++) send(-16'sd4000, 16'sd4000, "R1 bit alone");
      mute_bit = 1'b0; m_req = 1'b0;
      for (int i = 0; i < 12; i++) send(16'sd500, -16'sd500, "R4 recover");

      settle(4);
      check(q_l.size() == 0, "R6 scoreboard drained", q_l.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule